// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end of a NOR flash macro. Bus write cycles, each an address and a 16-bit data word, are decoded as commands that pick what a read returns (array contents, identifier codes or the status word). Two-cycle sequences start word programming and block erase. A running operation can be paused and later continued, and sticky failure flags are kept until software clears them. Reads are combinational from the current address and read mode.

The storage is a small behavioural array split into equal blocks. The lower half of the address space is bank I and the upper half is bank II; the address MSB selects the bank. Each block has a lock bit. Program and erase time is modelled by a down-counter, so the busy output stays high for a fixed, parameterised number of clock cycles.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset, reads return array data, every array word reads FFFFh, every lock bit is 0 (locked) and busy is low.
- R2: A write of FFh selects array reads. A write of 90h selects identifier reads, in which address 0 returns MFR_CODE, address 1 returns DEV_CODE and any other address returns 0.
- R3: A write of 70h selects status reads. A status read returns {8'h00, ready, suspended, erase_fail, program_fail, 2'b00, lock_fail, 1'b0}, where ready is bit 7 and is 0 only while busy. Any operation that starts or resumes forces status reads.
- R4: The erase_fail, program_fail and lock_fail bits stay set through all other commands. Only a 50h write while idle clears them, and it leaves the read mode unchanged.
- R5: 20h followed by D0h at an address inside a block erases that whole block to FFFFh when the operation ends. Other blocks keep their contents.
- R6: 40h followed by a write of address and data stores that word when the operation ends. If the target address is in bank II, nothing is stored, program_fail is set and status reads are selected.
- R7: While busy, B0h with an address in the same bank as the operation suspends it. Busy then goes low, and the suspended bit and the ready bit are both set. B0h with an address in the other bank is ignored. D0h in the matching bank resumes the operation from the held countdown, so busy lasts ERASE_CYC-1 more cycles when the erase was suspended on its second busy cycle.
- R8: While suspended, reads return status until FFh is written. After that, reads inside the suspended block still return status and reads elsewhere return array data.
- R9: With wp_n low, program or erase on a block whose lock bit is 0 is refused: lock_fail is set together with program_fail or erase_fail, and busy stays low. An erase that starts with wp_n high sets that block's lock bit to 1 when it ends.
- R10: If the write after 20h is not D0h in its low byte, the sequence is aborted, both erase_fail and program_fail are set, status reads are selected and the array is unchanged.
- R11: Busy rises on the clock edge that takes the confirming write and stays high for exactly PROG_CYC cycles for a program and ERASE_CYC cycles for an erase.
- R12: While busy, every write other than a matching B0h is ignored, read-mode changes included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we | input | 1 | Bus write strobe, one cycle per write |
| addr | input | AW | Word address for reads and writes |
| wdata | input | 16 | Write data; the command code is in the low byte |
| wp_n | input | 1 | Write-protect input, low enables lock checking |
| rdata | output | 16 | Read data for the current address and read mode |
| busy | output | 1 | High while a program or erase is running |

## Verification
The bench targets the suspend path. It first sends a suspend to the wrong bank, which a faulty design would obey and so halt the erase early. It then reads inside and outside the suspended block after FFh; a design that lets the suspended block through would return stale array data instead of status. The busy count after resume exposes a counter that restarts or loses its held value. The bench also checks that the fail flags stay set through FFh and 70h, that a write ignored during busy leaves status reads selected, and that an aborted confirm leaves the array untouched, because a design that starts the erase anyway would wipe a word the bench programmed earlier.

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
  parameter int AW = 8,
  parameter int BLK_W = 6,
  parameter int PROG_CYC = 4,
  parameter int ERASE_CYC = 12,
  parameter logic [15:0] MFR_CODE = 16'h00C3,
  parameter logic [15:0] DEV_CODE = 16'h4A51
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  input  logic          wp_n,
  output logic [15:0]   rdata,
  output logic          busy
);
  localparam int BW = AW - BLK_W;
  localparam int NBLK = 1 << BW;
  localparam int DEPTH = 1 << AW;
  localparam int BLK_WORDS = 1 << BLK_W;
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_ESETUP, S_PSETUP, S_BUSY, S_SUSP} st_t;
  typedef enum logic [1:0] {M_ARR, M_ID, M_STAT} mode_t;

  st_t st;
  mode_t mode;
  logic [CW-1:0] cnt;
  logic op_erase, op_setlock;
  logic [AW-1:0] op_addr;
  logic [15:0] op_data;
  logic ef, pf, lf;
  logic [NBLK-1:0] lock;
  logic [15:0] mem [DEPTH];
  logic [7:0] sr;

  wire [7:0] cmd = wdata[7:0];
  wire [BW-1:0] wblk = addr[AW-1:BLK_W];
  wire [BW-1:0] oblk = op_addr[AW-1:BLK_W];
  wire same_bank = addr[AW-1] == op_addr[AW-1];
  wire refused = !wp_n && !lock[wblk];
  wire susp = st == S_SUSP;
  wire sus_req = we && cmd == 8'hB0 && same_bank;
  wire finish = busy && cnt == '0 && !sus_req;

  assign busy = st == S_BUSY;
  assign sr = {~busy, susp, ef, pf, 2'b00, lf, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      mode <= M_ARR;
      cnt <= '0;
      op_erase <= 1'b0;
      op_setlock <= 1'b0;
      op_addr <= '0;
      op_data <= '0;
      ef <= 1'b0;
      pf <= 1'b0;
      lf <= 1'b0;
      lock <= '0;
    end else begin
      case (st)
        S_IDLE: if (we) begin
          case (cmd)
            8'hFF: mode <= M_ARR;
            8'h90: mode <= M_ID;
            8'h70: mode <= M_STAT;
            8'h50: begin ef <= 1'b0; pf <= 1'b0; lf <= 1'b0; end
            8'h20: st <= S_ESETUP;
            8'h40: st <= S_PSETUP;
            default: ;
          endcase
        end
        S_ESETUP: if (we) begin
          st <= S_IDLE;
          mode <= M_STAT;
          if (cmd != 8'hD0) begin
            ef <= 1'b1;
            pf <= 1'b1;
          end else if (refused) begin
            ef <= 1'b1;
            lf <= 1'b1;
          end else begin
            st <= S_BUSY;
            op_erase <= 1'b1;
            op_addr <= addr;
            op_setlock <= wp_n;
            cnt <= CW'(ERASE_CYC - 1);
          end
        end
        S_PSETUP: if (we) begin
          st <= S_IDLE;
          mode <= M_STAT;
          if (addr[AW-1]) begin
            pf <= 1'b1;
          end else if (refused) begin
            pf <= 1'b1;
            lf <= 1'b1;
          end else begin
            st <= S_BUSY;
            op_erase <= 1'b0;
            op_addr <= addr;
            op_data <= wdata;
            op_setlock <= 1'b0;
            cnt <= CW'(PROG_CYC - 1);
          end
        end
        S_BUSY: begin
          if (sus_req) st <= S_SUSP;
          else if (cnt == '0) begin
            st <= S_IDLE;
            if (op_erase && op_setlock) lock[oblk] <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        S_SUSP: if (we) begin
          case (cmd)
            8'hFF: mode <= M_ARR;
            8'h70: mode <= M_STAT;
            8'hD0: if (same_bank) begin
              st <= S_BUSY;
              mode <= M_STAT;
            end
            default: ;
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 16'hFFFF;
    end else if (finish) begin
      if (op_erase) begin
        for (int i = 0; i < BLK_WORDS; i++) mem[{oblk, i[BLK_W-1:0]}] <= 16'hFFFF;
      end else begin
        mem[op_addr] <= op_data;
      end
    end
  end

  always_comb begin
    case (mode)
      M_STAT: rdata = {8'h00, sr};
      M_ID: rdata = (addr == AW'(0)) ? MFR_CODE : (addr == AW'(1)) ? DEV_CODE : 16'h0000;
      default: rdata = (susp && wblk == oblk) ? {8'h00, sr} : mem[addr];
    endcase
  end
endmodule

// File: rtl/flash_cmd_fsm_chk.sv
module flash_cmd_fsm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        we,
  input logic [7:0]  cmd,
  input logic        wp_n,
  input logic [15:0] rdata,
  input logic        busy,
  input logic [7:0]  sr
);
  p_busy_by_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(we));

  p_start_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> rdata == {8'h00, sr});

  p_fail_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sr[5]) || $fell(sr[4]) || $fell(sr[1])) |-> ($past(we) && $past(cmd) == 8'h50));

  p_suspend_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr[6]) |-> ($past(we) && $past(cmd) == 8'hB0));

  p_resume_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr[6]) |-> busy);

  p_lockfail_wp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr[1]) |-> $past(!wp_n));
endmodule

bind flash_cmd_fsm flash_cmd_fsm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .cmd(wdata[7:0]), .wp_n(wp_n),
  .rdata(rdata), .busy(busy), .sr(sr)
);

// File: tb/flash_cmd_fsm_test.sv
module flash_cmd_fsm_test;
  localparam int PC = 4;
  localparam int EC = 12;
  localparam logic [15:0] MFR = 16'h00C3;
  localparam logic [15:0] DEV = 16'h4A51;

  logic clk = 0, rst_n = 0, we = 0, wp_n = 1;
  logic [7:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic busy;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  flash_cmd_fsm #(.AW(8), .BLK_W(6), .PROG_CYC(PC), .ERASE_CYC(EC),
                  .MFR_CODE(MFR), .DEV_CODE(DEV)) uut (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .wp_n(wp_n), .rdata(rdata), .busy(busy));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rdc(input logic [7:0] a, input logic [15:0] exp, input string tag);
    addr = a;
    #1;
    chk({16'h0, rdata}, {16'h0, exp}, tag);
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk({31'h0, busy}, 0, "R1 busy low after reset");
    rdc(8'h05, 16'hFFFF, "R1 array read after reset");
    wr(0, 16'h70);
    rdc(0, 16'h0080, "R1 R3 idle status");
  endtask

  task automatic t_id;
    wr(0, 16'h90);
    rdc(0, MFR, "R2 manufacturer code");
    rdc(1, DEV, "R2 device code");
    rdc(2, 16'h0000, "R2 other id address");
    wr(0, 16'hFF);
    rdc(0, 16'hFFFF, "R2 back to array");
  endtask

  task automatic t_locked;
    wp_n = 0;
    wr(0, 16'h40); wr(3, 16'h1234);
    chk({31'h0, busy}, 0, "R9 locked program not started");
    rdc(3, 16'h0092, "R9 lock and program fail");
    wr(0, 16'hFF);
    rdc(3, 16'hFFFF, "R9 locked word unchanged");
    wr(0, 16'h20); wr(8'h80, 16'hD0);
    rdc(0, 16'h00B2, "R9 locked erase adds erase fail");
    wr(0, 16'h50); wr(0, 16'h70);
    rdc(0, 16'h0080, "R4 clear status");
  endtask

  task automatic t_program;
    int n;
    wp_n = 1;
    wr(0, 16'h40); wr(3, 16'h1234);
    count_busy(n);
    chk(n, PC, "R11 program busy cycles");
    rdc(3, 16'h0080, "R3 status after program");
    wr(0, 16'hFF);
    rdc(3, 16'h1234, "R6 programmed word");
    wr(0, 16'h40); wr(8'h41, 16'h7777);
    count_busy(n);
    wr(0, 16'hFF);
    rdc(8'h41, 16'h7777, "R6 second programmed word");
  endtask

  task automatic t_erase;
    int n;
    wp_n = 1;
    wr(0, 16'h20); wr(8'h05, 16'hD0);
    count_busy(n);
    chk(n, EC, "R11 erase busy cycles");
    wr(0, 16'hFF);
    rdc(3, 16'hFFFF, "R5 block erased");
    rdc(8'h41, 16'h7777, "R5 other block kept");
    wp_n = 0;
    wr(0, 16'h40); wr(4, 16'hABCD);
    count_busy(n);
    chk(n, PC, "R9 erase set lock bit, program allowed");
    wr(0, 16'hFF);
    rdc(4, 16'hABCD, "R9 program on unlocked block");
    wp_n = 1;
  endtask

  task automatic t_bank2;
    wr(0, 16'h40); wr(8'h80, 16'h5555);
    chk({31'h0, busy}, 0, "R6 bank II program refused");
    rdc(0, 16'h0090, "R6 program fail set");
    wr(0, 16'hFF);
    rdc(8'h80, 16'hFFFF, "R6 bank II word unchanged");
    wr(0, 16'h70);
    rdc(0, 16'h0090, "R4 fail bit sticky");
    wr(0, 16'h50);
    rdc(0, 16'h0080, "R4 cleared by 50h");
  endtask

  task automatic t_bad_confirm;
    wr(0, 16'h20); wr(8'h10, 16'h00FF);
    chk({31'h0, busy}, 0, "R10 aborted erase not busy");
    rdc(0, 16'h00B0, "R10 both fail bits");
    wr(0, 16'hFF);
    rdc(4, 16'hABCD, "R10 array untouched");
    wr(0, 16'h50);
  endtask

  task automatic t_suspend;
    int n;
    wr(0, 16'h20); wr(8'h41, 16'hD0);
    wr(8'h80, 16'hB0);
    chk({31'h0, busy}, 1, "R7 wrong bank suspend ignored");
    wr(8'h40, 16'hB0);
    chk({31'h0, busy}, 0, "R7 suspended not busy");
    rdc(3, 16'h00C0, "R8 status while suspended");
    wr(0, 16'hFF);
    rdc(4, 16'hABCD, "R8 other block array");
    rdc(8'h41, 16'h00C0, "R8 suspended block gives status");
    wr(8'h40, 16'hD0);
    rdc(0, 16'h0000, "R7 resumed busy status");
    count_busy(n);
    chk(n, EC - 1, "R7 remaining erase cycles");
    wr(0, 16'hFF);
    rdc(8'h41, 16'hFFFF, "R5 erase completed after resume");
  endtask

  task automatic t_busy_ignore;
    int n;
    wr(0, 16'h40); wr(5, 16'h1111);
    rdc(0, 16'h0000, "R3 status forced on start");
    wr(0, 16'hFF);
    rdc(0, 16'h0000, "R12 FFh ignored while busy");
    count_busy(n);
    chk(n, PC - 1, "R12 countdown unaffected");
    rdc(0, 16'h0080, "R12 mode still status");
    wr(0, 16'hFF);
    rdc(5, 16'h1111, "R6 word after ignored write");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_id();
    t_locked();
    t_program();
    t_erase();
    t_bank2();
    t_bad_confirm();
    t_suspend();
    t_busy_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule